// File: doc/BRIEF.md
# Video Presence Monitor and Splash Switch

This block sits behind the clock-crossing FIFO that brings an external pixel stream into a fixed local clock domain. Every part of it runs on that one local clock, and it never switches clock sources. The block does not look at the foreign pixel clock at all. It counts, over a fixed window of `WIN_LEN` local cycles, how many cycles the FIFO reported data (empty flag low). That count is published as a coarse estimate of the incoming rate. A stopped source leaves the empty flag high while the local clock keeps running, so a stopped source gives a count of zero.

A three-state presence machine compares each window's count with a threshold. The states are ABSENT, ARMED and PRESENT:
- ABSENT→ARMED on a window at or above the threshold.
- ARMED→PRESENT on a second such window in a row. This transition also starts the FIFO reset pulse.
- ARMED→ABSENT on a window below the threshold.
- PRESENT→ABSENT on any single window below the threshold.

A two-state output machine picks what is sent. Its states are SPLASH and VIDEO, and it changes only on the last pixel of a splash frame:
- SPLASH→VIDEO when video is present at that pixel.
- VIDEO→SPLASH when video is absent at that pixel.

In SPLASH it sends vertical colour bars built from free-running column and row counters. In VIDEO it sends the bridged FIFO data, with the FIFO's non-empty state as the data-valid.

Top module: `video_presence_switch`

## Requirements
- R1: A window covers `WIN_LEN` consecutive local cycles, starting with the first clock edge after reset. In the cycle after a window's last cycle, `rate_valid` is high for exactly one cycle, and `rate_est` holds the number of that window's cycles in which `fifo_empty` was low.
- R2: The window count saturates at 2^`CNT_W`-1 instead of wrapping.
- R3: A window counts as "above" when `rate_est >= thresh`. `video_present` rises only after two consecutive above windows: ABSENT→ARMED→PRESENT. An ARMED machine that sees a below window returns to ABSENT. Each state change appears one cycle after the `rate_valid` pulse.
- R4: In PRESENT, a single below window clears `video_present` one cycle after the `rate_valid` pulse. A source whose `fifo_empty` stays high therefore reads as a rate of 0 and as absent.
- R5: `fifo_rst` goes high in the same cycle that `video_present` rises. It stays high for exactly `RST_HOLD` cycles and is low at all other times.
- R6: In SPLASH, `out_valid` is 1 and each column h of an `H_PIX` by `V_LINES` frame shows bar b = (h >> `BAR_SHIFT`) mod 8. The colour is RGB565:
  - bits 15:11 are all ones when b bit 2 is set;
  - bits 10:5 are all ones when b bit 1 is set;
  - bits 4:0 are all ones when b bit 0 is set;
  - every other field is zero.
- R7: `out_is_video` changes only on the first output pixel of a splash frame (column 0, row 0). It then follows the value `video_present` had on the last pixel of the previous frame.
- R8: In VIDEO, `out_pix` equals `fifo_data`, and `out_valid` equals the inverse of `fifo_empty`, both taken from the previous cycle.
- R9: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Constant local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Empty flag of the bridge FIFO, local domain |
| fifo_data | input | 16 | FIFO read data, always-on read |
| thresh | input | CNT_W | Presence threshold, in non-empty cycles per window |
| fifo_rst | output | 1 | Reset pulse to the bridge FIFO |
| video_present | output | 1 | Debounced presence flag |
| rate_est | output | CNT_W | Non-empty count of the last window |
| rate_valid | output | 1 | One-cycle strobe when `rate_est` updates |
| out_pix | output | 16 | Pixel sent downstream |
| out_valid | output | 1 | `out_pix` is valid |
| out_is_video | output | 1 | 1 when `out_pix` carries bridged video |

## Verification
- `rate_est` and `rate_valid` are due on the edge that closes a window.
- `video_present` and `fifo_rst` are due one edge later.
- A change of mode shows on `out_is_video` two edges after the last splash pixel has been counted.
- Pixel outputs lag their inputs by one edge.

The bench reference model advances on each rising edge, using exactly this latency, and every output is compared at the following falling edge. The non-empty patterns repeat with a period of one window and are aligned to windows, so each window has an exact count. The phase checks read `rate_est` one cycle into the next phase and `video_present` two cycles in, which matches the latencies above.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    localparam int PIX_W = 16;

    typedef enum logic [1:0] {
        PRES_ABSENT  = 2'd0,
        PRES_ARMED   = 2'd1,
        PRES_PRESENT = 2'd2
    } pres_state_t;

    typedef enum logic {
        MUX_SPLASH = 1'b0,
        MUX_VIDEO  = 1'b1
    } mux_state_t;

    // RGB565 colour of one of eight bars: each index bit fills one channel.
    function automatic logic [PIX_W-1:0] bar_colour(input logic [2:0] idx);
        return {{5{idx[2]}}, {6{idx[1]}}, {5{idx[0]}}};
    endfunction

endpackage

// File: rtl/vpm_window_meter.sv
module vpm_window_meter #(
    parameter int WIN_LEN = 65536,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    output logic [CNT_W-1:0] rate_est,
    output logic             rate_valid
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_inc;
    logic             win_last;

    assign win_last = (win_cnt == WIN_LAST);
    assign acc_inc  = (fifo_empty || acc == CNT_MAX) ? acc : acc + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt    <= '0;
            acc        <= '0;
            rate_est   <= '0;
            rate_valid <= 1'b0;
        end else begin
            rate_valid <= win_last;
            if (win_last) begin
                win_cnt  <= '0;
                acc      <= '0;
                rate_est <= acc_inc;
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                acc      <= acc_inc;
            end
        end
    end

endmodule

// File: rtl/vpm_presence_fsm.sv
module vpm_presence_fsm
    import vpm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RST_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_valid,
    input  logic [CNT_W-1:0] rate_est,
    input  logic [CNT_W-1:0] thresh,
    output logic             video_present,
    output logic             fifo_rst
);
    localparam int HOLD_W = $clog2(RST_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_HOLD);

    pres_state_t      state, state_nx;
    logic             above;
    logic             enter_present;
    logic [HOLD_W-1:0] hold_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PRES_ABSENT;
        else        state <= state_nx;
    end

    // Next state: evaluated only when a window closes
    always_comb begin
        above    = (rate_est >= thresh);
        state_nx = state;
        if (rate_valid) begin
            unique case (state)
                PRES_ABSENT:  if (above) state_nx = PRES_ARMED;
                PRES_ARMED:   state_nx = above ? PRES_PRESENT : PRES_ABSENT;
                PRES_PRESENT: if (!above) state_nx = PRES_ABSENT;
                default:      state_nx = PRES_ABSENT;
            endcase
        end
    end

    assign enter_present = (state == PRES_ARMED) && (state_nx == PRES_PRESENT);

    // Outputs: FIFO reset stretch counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hold_cnt <= '0;
        else if (enter_present)    hold_cnt <= HOLD_LOAD;
        else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
    end

    assign fifo_rst      = (hold_cnt != '0);
    assign video_present = (state == PRES_PRESENT);

endmodule

// File: rtl/vpm_splash_gen.sv
module vpm_splash_gen
    import vpm_pkg::*;
#(
    parameter int H_PIX     = 800,
    parameter int V_LINES   = 525,
    parameter int BAR_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PIX_W-1:0] splash_pix,
    output logic             frame_last
);
    localparam int H_W = (H_PIX > 1) ? $clog2(H_PIX) : 1;
    localparam int V_W = (V_LINES > 1) ? $clog2(V_LINES) : 1;
    localparam logic [H_W-1:0] H_LAST = H_W'(H_PIX - 1);
    localparam logic [V_W-1:0] V_LAST = V_W'(V_LINES - 1);

    logic [H_W-1:0] col;
    logic [V_W-1:0] row;
    logic           line_last;
    logic [31:0]    bar_num;

    assign line_last  = (col == H_LAST);
    assign frame_last = line_last && (row == V_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (line_last) begin
            col <= '0;
            row <= (row == V_LAST) ? '0 : row + 1'b1;
        end else begin
            col <= col + 1'b1;
        end
    end

    assign bar_num    = 32'(col) >> BAR_SHIFT;
    assign splash_pix = bar_colour(bar_num[2:0]);

endmodule

// File: rtl/video_presence_switch.sv
module video_presence_switch
    import vpm_pkg::*;
#(
    parameter int WIN_LEN   = 65536,
    parameter int CNT_W     = 16,
    parameter int RST_HOLD  = 4,
    parameter int H_PIX     = 800,
    parameter int V_LINES   = 525,
    parameter int BAR_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  logic [15:0]      fifo_data,
    input  logic [CNT_W-1:0] thresh,
    output logic             fifo_rst,
    output logic             video_present,
    output logic [CNT_W-1:0] rate_est,
    output logic             rate_valid,
    output logic [15:0]      out_pix,
    output logic             out_valid,
    output logic             out_is_video
);
    logic [PIX_W-1:0] splash_pix;
    logic             frame_last;
    mux_state_t       mux_st, mux_nx;

    vpm_window_meter #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .rate_est   (rate_est),
        .rate_valid (rate_valid)
    );

    vpm_presence_fsm #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_presence (
        .clk           (clk),
        .rst_n         (rst_n),
        .rate_valid    (rate_valid),
        .rate_est      (rate_est),
        .thresh        (thresh),
        .video_present (video_present),
        .fifo_rst      (fifo_rst)
    );

    vpm_splash_gen #(.H_PIX(H_PIX), .V_LINES(V_LINES), .BAR_SHIFT(BAR_SHIFT)) u_splash (
        .clk        (clk),
        .rst_n      (rst_n),
        .splash_pix (splash_pix),
        .frame_last (frame_last)
    );

    // Output selector state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mux_st <= MUX_SPLASH;
        else        mux_st <= mux_nx;
    end

    // Transitions only on the last splash pixel of a frame
    always_comb begin
        mux_nx = mux_st;
        unique case (mux_st)
            MUX_SPLASH: if (frame_last && video_present)  mux_nx = MUX_VIDEO;
            MUX_VIDEO:  if (frame_last && !video_present) mux_nx = MUX_SPLASH;
            default:    mux_nx = MUX_SPLASH;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pix      <= '0;
            out_valid    <= 1'b0;
            out_is_video <= 1'b0;
        end else begin
            unique case (mux_st)
                MUX_VIDEO: begin
                    out_pix      <= fifo_data;
                    out_valid    <= !fifo_empty;
                    out_is_video <= 1'b1;
                end
                default: begin
                    out_pix      <= splash_pix;
                    out_valid    <= 1'b1;
                    out_is_video <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
    parameter int RST_HOLD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic video_present,
    input logic fifo_rst,
    input logic rate_valid,
    input logic out_is_video,
    input logic frame_last
);
    int run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run <= 0;
        else if (fifo_rst) run <= run + 1;
        else               run <= 0;
    end

    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !rate_valid);

    a_r3_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_present) |-> $past(rate_valid));

    a_r4_fall_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(video_present) |-> $past(rate_valid));

    a_r5_pulse_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_present) |-> $rose(fifo_rst));

    a_r5_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |-> (run < RST_HOLD));

    a_r5_pulse_full_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_rst) |-> (run == RST_HOLD));

    a_r7_switch_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_video != $past(out_is_video)) |-> $past(frame_last, 2));

endmodule

bind video_presence_switch vpm_checker #(.RST_HOLD(RST_HOLD)) u_vpm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .video_present (video_present),
    .fifo_rst      (fifo_rst),
    .rate_valid    (rate_valid),
    .out_is_video  (out_is_video),
    .frame_last    (frame_last)
);

// File: tb/test_video_presence_switch.sv
module test_video_presence_switch;
    localparam int WIN   = 64;
    localparam int CW    = 6;
    localparam int HOLD  = 4;
    localparam int HP    = 16;
    localparam int VL    = 4;
    localparam int BS    = 1;
    localparam int THR   = 40;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_empty = 1'b1;
    logic [15:0]   fifo_data = '0;
    logic [CW-1:0] thresh = CW'(THR);
    logic          fifo_rst, video_present, rate_valid, out_valid, out_is_video;
    logic [CW-1:0] rate_est;
    logic [15:0]   out_pix;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    video_presence_switch #(
        .WIN_LEN(WIN), .CNT_W(CW), .RST_HOLD(HOLD),
        .H_PIX(HP), .V_LINES(VL), .BAR_SHIFT(BS)
    ) i_video_presence_switch (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .thresh(thresh), .fifo_rst(fifo_rst), .video_present(video_present),
        .rate_est(rate_est), .rate_valid(rate_valid), .out_pix(out_pix),
        .out_valid(out_valid), .out_is_video(out_is_video)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int splash_ref(input int col);
        int bar, r, g, b;
        bar = (col / (1 << BS)) % 8;
        r = ((bar / 4) % 2 == 1) ? 31 : 0;
        g = ((bar / 2) % 2 == 1) ? 63 : 0;
        b = (bar % 2 == 1) ? 31 : 0;
        return r * 2048 + g * 32 + b;
    endfunction

    // Behavioural reference model
    int m_col, m_row, m_wpos, m_acc, m_rate, m_pres, m_hold, m_mode;
    int m_pix, m_valid, m_vid, m_done;
    int t_above, t_enter, t_last, t_ne;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_col = 0; m_row = 0; m_wpos = 0; m_acc = 0; m_rate = 0;
            m_pres = 0; m_hold = 0; m_mode = 0; m_pix = 0; m_valid = 0;
            m_vid = 0; m_done = 0;
        end else begin
            t_last = (m_col == HP - 1 && m_row == VL - 1) ? 1 : 0;
            if (m_mode == 0) begin
                m_pix = splash_ref(m_col); m_valid = 1; m_vid = 0;
            end else begin
                m_pix = int'(fifo_data); m_valid = fifo_empty ? 0 : 1; m_vid = 1;
            end
            if (t_last == 1) m_mode = (m_pres == 2) ? 1 : 0;
            t_enter = 0;
            if (m_done == 1) begin
                t_above = (m_rate >= THR) ? 1 : 0;
                if (m_pres == 0) begin
                    if (t_above == 1) m_pres = 1;
                end else if (m_pres == 1) begin
                    if (t_above == 1) begin m_pres = 2; t_enter = 1; end
                    else m_pres = 0;
                end else begin
                    if (t_above == 0) m_pres = 0;
                end
            end
            if (t_enter == 1) m_hold = HOLD;
            else if (m_hold > 0) m_hold--;
            t_ne = fifo_empty ? 0 : 1;
            m_done = 0;
            if (m_wpos == WIN - 1) begin
                m_rate = (m_acc + t_ne > CMAX) ? CMAX : m_acc + t_ne;
                m_acc = 0; m_wpos = 0; m_done = 1;
            end else begin
                m_acc = (m_acc + t_ne > CMAX) ? CMAX : m_acc + t_ne;
                m_wpos++;
            end
            if (m_col == HP - 1) begin
                m_col = 0;
                m_row = (m_row == VL - 1) ? 0 : m_row + 1;
            end else m_col++;
        end
    end

    int rst_hi = 0;
    int pres_seen = 0;

    task automatic compare_all();
        check("R1", "rate_est", int'(rate_est), m_rate);
        check("R1", "rate_valid", int'(rate_valid), m_done);
        check("R3", "video_present", int'(video_present), (m_pres == 2) ? 1 : 0);
        check("R5", "fifo_rst", int'(fifo_rst), (m_hold != 0) ? 1 : 0);
        check("R7", "out_is_video", int'(out_is_video), m_vid);
        if (m_vid == 1) begin
            check("R8", "out_pix", int'(out_pix), m_pix);
            check("R8", "out_valid", int'(out_valid), m_valid);
        end else begin
            check("R6", "out_pix", int'(out_pix), m_pix);
            check("R6", "out_valid", int'(out_valid), m_valid);
        end
        if (fifo_rst) rst_hi++;
        if (video_present) pres_seen++;
    endtask

    int k = 0;
    int prev_rate = -1;
    int prev_pres = -1;
    string prev_req = "";

    // Run wins windows with n non-empty cycles per window; verify previous phase.
    task automatic phase(input int n, input int wins, input int exp_rate, input int exp_pres,
                         input string req);
        for (int i = 0; i < wins * WIN; i++) begin
            @(negedge clk);
            compare_all();
            if (i == 0 && prev_rate >= 0)
                check(prev_req, "phase rate_est", int'(rate_est), prev_rate);
            if (i == 1 && prev_pres >= 0)
                check(prev_req, "phase video_present", int'(video_present), prev_pres);
            fifo_empty = ((k % WIN) < n) ? 1'b0 : 1'b1;
            fifo_data  = 16'(k * 40503) ^ 16'h5A5A;
            k++;
        end
        prev_rate = exp_rate;
        prev_pres = exp_pres;
        prev_req  = req;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "reset video_present", int'(video_present), 0);
        check("R9", "reset fifo_rst", int'(fifo_rst), 0);
        check("R9", "reset rate_est", int'(rate_est), 0);
        check("R9", "reset out_valid", int'(out_valid), 0);
        check("R9", "reset out_pix", int'(out_pix), 0);
        check("R9", "reset out_is_video", int'(out_is_video), 0);
        rst_n = 1'b1;
        k = 0;
        fifo_empty = 1'b1;
        // R4: stopped source, empty held high
        phase(0, 3, 0, 0, "R4");
        // R2: full windows saturate; R3: present after two windows
        phase(WIN, 3, CMAX, 1, "R2");
        phase(48, 2, 48, 1, "R1");
        // R4: one below window drops presence
        phase(32, 1, 32, 0, "R4");
        // R3: count exactly at threshold counts as above
        phase(THR, 2, THR, 1, "R3");
        phase(THR - 1, 1, THR - 1, 0, "R4");
        // R3: a single above window only arms
        pres_seen = 0;
        phase(WIN, 1, CMAX, 0, "R3");
        phase(0, 2, 0, 0, "R3");
        phase(0, 1, 0, 0, "R3");
        check("R3", "single above window never presents", pres_seen, 0);
        // R5: two entries to PRESENT, each a pulse of HOLD cycles
        check("R5", "total fifo_rst high cycles", rst_hi, 2 * HOLD);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule